// File: doc/BRIEF.md
# Pulse-Driven Six-Bit Step Counter

This block holds an 8-bit converter code and moves it in coarse steps when a slow control line is pulsed. Each rising edge on the pulse line moves the upper six bits of the code by one count. One count is four codes of the full 8-bit value. Pulse operation always writes the two least significant bits as zero.

Two step policies are available. In increment-only operation the code only ever rises, and it wraps from the top step back to zero. In that policy a run of 63 pulses has the same effect as one step down. In up/down operation a direction line picks the way of each step, and the count sticks at the top step and at zero rather than wrapping.

The pulse line is resynchronised to the system clock and its rising edges are detected there. The direction line is read in the system-clock cycle in which an edge is found. A parallel load sets the code when the surrounding logic hands control to this block. A loaded value may have non-zero low bits. The first step after the load clears them.

Top module: `pulse_step_counter`

## Requirements
- R1: After synchronous reset the code output is 8'h80 (midscale).
- R2: In increment-only operation (updown_mode=0) each accepted rising edge of pulse_in adds 4 to code_out. Bits [1:0] of the result are 0.
- R3: In increment-only operation a step from 8'hFC gives 8'h00. From any start, 64 steps return to the start value and 63 steps equal one step down.
- R4: In up/down operation (updown_mode=1), dir_up=1 adds 4 per step and dir_up=0 subtracts 4 per step.
- R5: In up/down operation the code stays at 8'hFC on further up steps and at 8'h00 on further down steps.
- R6: One step is taken per rising edge of pulse_in. Holding pulse_in high, or a falling edge, leaves the code unchanged.
- R7: While enable=0, pulses leave the code unchanged.
- R8: load_en=1 writes load_code into the code on the next clock edge. The load takes priority over a step in the same cycle.
- R9: A loaded code whose bits [1:0] are non-zero has those bits cleared by the first step. The upper six bits are stepped or saturated as usual.
- R10: In increment-only operation the level of dir_up has no effect on the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Step pulse line; it may be asynchronous to clk |
| dir_up | input | 1 | Step direction in up/down operation: 1 up, 0 down |
| updown_mode | input | 1 | 0 selects increment-only operation, 1 selects up/down operation |
| enable | input | 1 | 1 lets detected edges take a step |
| load_en | input | 1 | Parallel load strobe |
| load_code | input | 8 | Value written by the load |
| code_out | output | 8 | Current converter code |

## Verification
A wrong step count or a wrong wrap decision shows on code_out a fixed number of cycles after the pulse edge. That delay is the synchroniser depth plus one register, so a comparison against an arithmetic model after each pulse finds the error at the pulse where it happens. The bench sweeps every step position in both policies. This covers the two saturation points and the single wrap point. A low bit left set after a load, or a double step from a long high pulse, also shows as a code mismatch at the next check.

// File: rtl/pstep_pkg.sv
package pstep_pkg;
    localparam int CODE_W  = 8;
    localparam int LOW_W   = 2;
    localparam int FIELD_W = CODE_W - LOW_W;
    localparam logic [FIELD_W-1:0] FIELD_MAX = {FIELD_W{1'b1}};
    localparam logic [CODE_W-1:0]  MID_CODE  = CODE_W'(1) << (CODE_W - 1);

    typedef enum logic {
        MODE_INC_ONLY = 1'b0,
        MODE_UPDOWN   = 1'b1
    } step_mode_e;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic [LOW_W-1:0]   low;
    } code_t;

    function automatic logic [FIELD_W-1:0] step_field(
        input logic [FIELD_W-1:0] cur,
        input step_mode_e         mode,
        input logic               up
    );
        logic [FIELD_W-1:0] nxt;
        if (mode == MODE_INC_ONLY) begin
            nxt = cur + 1'b1;
        end else if (up) begin
            nxt = (cur == FIELD_MAX) ? cur : cur + 1'b1;
        end else begin
            nxt = (cur == '0) ? cur : cur - 1'b1;
        end
        return nxt;
    endfunction
endpackage

// File: rtl/pstep_edge.sv
module pstep_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise_o
);
    logic sig_s;
    logic sig_prev;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign sig_s = sig_in;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], sig_in};
            end
            assign sig_s = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sig_prev <= 1'b1;
        else     sig_prev <= sig_s;
    end

    assign rise_o = sig_s & ~sig_prev;
endmodule

// File: rtl/pstep_next.sv
module pstep_next
    import pstep_pkg::*;
(
    input  code_t      cur,
    input  step_mode_e mode,
    input  logic       up,
    output code_t      nxt
);
    always_comb begin
        nxt.field = step_field(cur.field, mode, up);
        nxt.low   = '0;
    end
endmodule

// File: rtl/pulse_step_counter.sv
module pulse_step_counter
    import pstep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_in,
    input  logic              dir_up,
    input  logic              updown_mode,
    input  logic              enable,
    input  logic              load_en,
    input  logic [CODE_W-1:0] load_code,
    output logic [CODE_W-1:0] code_out
);
    logic       rise;
    code_t      code_q;
    code_t      code_step;
    step_mode_e mode;

    assign mode = updown_mode ? MODE_UPDOWN : MODE_INC_ONLY;

    pstep_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (pulse_in),
        .rise_o (rise)
    );

    pstep_next u_next (
        .cur  (code_q),
        .mode (mode),
        .up   (dir_up),
        .nxt  (code_step)
    );

    always_ff @(posedge clk) begin
        if (rst)                 code_q <= code_t'(MID_CODE);
        else if (load_en)        code_q <= code_t'(load_code);
        else if (rise && enable) code_q <= code_step;
    end

    assign code_out = code_q;

    // R1
    reset_mid_chk: assert property (@(posedge clk) rst |=> code_out == MID_CODE);

    // R6
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise && !load_en) |=> $stable(code_out));

    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!enable && !load_en) |=> $stable(code_out));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> code_out == $past(load_code));

    // R3
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && enable && !load_en && !updown_mode && code_out[CODE_W-1:LOW_W] == FIELD_MAX)
        |=> code_out == '0);

    // R5
    top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && enable && !load_en && updown_mode && dir_up && code_out[CODE_W-1:LOW_W] == FIELD_MAX)
        |=> code_out == {FIELD_MAX, {LOW_W{1'b0}}});

    // R5
    bottom_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && enable && !load_en && updown_mode && !dir_up && code_out[CODE_W-1:LOW_W] == '0)
        |=> code_out == '0);

    // R9
    low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && enable && !load_en) |=> code_out[LOW_W-1:0] == '0);
endmodule

// File: tb/pulse_step_counter_bench.sv
module pulse_step_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_in = 1'b0;
    logic       dir_up = 1'b1;
    logic       updown_mode = 1'b0;
    logic       enable = 1'b1;
    logic       load_en = 1'b0;
    logic [7:0] load_code = 8'h00;
    logic [7:0] code_out;

    int errors = 0;
    int checks = 0;
    logic [7:0] model;

    always #4 clk = ~clk;

    pulse_step_counter u_pulse_step_counter (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .dir_up(dir_up),
        .updown_mode(updown_mode), .enable(enable), .load_en(load_en),
        .load_code(load_code), .code_out(code_out)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if (code_out !== exp) begin
            errors++;
            $display("FAIL %s: code_out=%h expected=%h", req, code_out, exp);
        end
    endtask

    // Arithmetic model of one step
    function automatic logic [7:0] model_step(input logic [7:0] c, input logic ud, input logic up);
        int f;
        f = int'(c[7:2]);
        if (!ud)      f = (f + 1) % 64;
        else if (up)  f = (f == 63) ? 63 : f + 1;
        else          f = (f == 0) ? 0 : f - 1;
        return 8'(f * 4);
    endfunction

    task automatic pulse(input int high_cycles);
        @(negedge clk) pulse_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        pulse_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        @(negedge clk) begin load_en = 1'b1; load_code = v; end
        @(negedge clk) load_en = 1'b0;
        model = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        model = 8'h80;
        check("R1", model);

        // Increment-only sweep over all 64 positions, dir toggling (R2, R3, R10)
        updown_mode = 1'b0;
        for (int i = 0; i < 64; i++) begin
            dir_up = i[0];
            pulse(4);
            model = model_step(model, 1'b0, dir_up);
            check(i[0] ? "R2" : "R10", model);
        end
        check("R3", 8'h80);

        // 63 pulses act as one step down (R3)
        for (int i = 0; i < 63; i++) pulse(2);
        check("R3", 8'h7C);
        model = 8'h7C;

        // Wrap from top (R3)
        do_load(8'hFC);
        pulse(2);
        check("R3", 8'h00);
        model = 8'h00;

        // Long high level: a single step (R6)
        pulse(12);
        model = model_step(model, 1'b0, 1'b1);
        check("R6", model);

        // Enable low ignores pulses (R7)
        enable = 1'b0;
        pulse(3); pulse(3);
        check("R7", model);
        enable = 1'b1;

        // Up/down: climb to the top and beyond (R4, R5)
        updown_mode = 1'b1;
        dir_up = 1'b1;
        do_load(8'hE0);
        for (int i = 0; i < 11; i++) begin
            pulse(2);
            model = model_step(model, 1'b1, 1'b1);
            check(i < 7 ? "R4" : "R5", model);
        end
        check("R5", 8'hFC);

        // Down across the whole range to zero and beyond (R4, R5)
        dir_up = 1'b0;
        for (int i = 0; i < 66; i++) begin
            pulse(2);
            model = model_step(model, 1'b1, 1'b0);
            check(i < 63 ? "R4" : "R5", model);
        end
        check("R5", 8'h00);

        // Load held across a pulse wins (R8)
        @(negedge clk) begin load_en = 1'b1; load_code = 8'h57; end
        pulse(3);
        load_en = 1'b0;
        @(negedge clk);
        check("R8", 8'h57);

        // Low bits cleared by first step (R9)
        dir_up = 1'b1;
        pulse(2);
        check("R9", 8'h58);
        do_load(8'h03);
        dir_up = 1'b0;
        pulse(2);
        check("R9", 8'h00);
        do_load(8'hFF);
        dir_up = 1'b1;
        pulse(2);
        check("R9", 8'hFC);
        updown_mode = 1'b0;
        do_load(8'hFE);
        pulse(2);
        check("R9", 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: code_out=%h expected=finished", code_out);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule